// File: doc/BRIEF.md
# Packed BCD Add/Subtract Unit

This unit adds or subtracts two packed decimal bytes, each holding two BCD digits, and returns the decimal result with a full set of condition flags. An extend bit acts as the carry-in for addition and as the borrow-in for subtraction. A caller can therefore run a multi-byte decimal number through the unit one byte at a time. It starts at the least significant byte and feeds each extend output back as the next extend input.

The zero flag is also fed back between bytes. It is never set by the unit, only cleared. A chain of byte operations reports zero only when every byte of the chained result was zero.

The destination operand is a full register. Only its low byte is replaced, and the rest of it passes through unchanged. A one-cycle start strobe launches an operation. The result and all flags appear in registers on the following cycle, and they hold there until the next strobe.

Top module: `bcd_arith_unit`

## Requirements
- R1: While reset is asserted (synchronous, active low), `valid_o`, `result_o` and all five flag outputs are 0.
- R2: An operation whose `start_i` is sampled high at a clock edge shows its result and flags right after that edge, with `valid_o` high for that one cycle. When `start_i` is low, `valid_o` is 0 and the result and flags keep their values.
- R3: With `sub_i` = 0 and both bytes valid BCD (each nibble 0..9), the result byte is the BCD form of (dst + src + x_i) mod 100, and a carry is produced when that sum is 100 or more.
- R4: With `sub_i` = 1 and both bytes valid BCD, the result byte is the BCD form of (dst - src - x_i) mod 100, and a borrow is produced when that difference is below zero.
- R5: `x_o` and `c_o` both equal the decimal carry (when adding) or borrow (when subtracting). This is any bit above bit 7 of the corrected 10-bit intermediate.
- R6: `z_o` is `z_i` when the result byte is zero, and 0 otherwise.
- R7: `n_o` is bit 7 of the result byte.
- R8: `v_o` is bit 7 of (~(src ^ dst) & (dst ^ res)) when adding, and bit 7 of ((src ^ dst) & (dst ^ res)) when subtracting. Here res is the result byte.
- R9: Bits 31..8 of `result_o` equal bits 31..8 of `dst_i` as sampled with the strobe.
- R10: All operands, including non-BCD nibbles, follow this 10-bit wrapping computation:
  - Low step: the low nibbles are combined with `x_i`, added when adding and subtracted when subtracting.
  - Low correction: if that value, read as unsigned, is above 9, 6 is added (adding) or taken away (subtracting).
  - High step: dst[7:4]<<4 is added and src[7:4]<<4 is subtracted when subtracting. When adding, both are added.
  - High correction: if the total, read as unsigned, is above 0x99, 0x60 is applied in the same direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launches one operation |
| sub_i | input | 1 | 0 = add, 1 = subtract (dst - src) |
| src_i | input | 8 | Source packed BCD byte |
| dst_i | input | 32 | Destination register; low byte is the operand |
| x_i | input | 1 | Extend flag in (carry/borrow in) |
| z_i | input | 1 | Zero flag in, for chaining |
| valid_o | output | 1 | High for one cycle with a new result |
| result_o | output | 32 | Destination with its low byte replaced |
| x_o | output | 1 | Extend flag out |
| c_o | output | 1 | Carry flag out |
| z_o | output | 1 | Zero flag out |
| n_o | output | 1 | Negative flag out |
| v_o | output | 1 | Overflow flag out |

## Verification
The only state the unit keeps is its output registers, so every internal fault appears at the ports on the cycle after the strobe that exposes it:
- A wrong digit correction shows up as a non-decimal or off-by-six digit in `result_o`.
- A missed carry or borrow shows up in `x_o` and `c_o` together.
- A lost zero chain shows up as `z_o` set after a nonzero byte.

A register that fails to hold shows up during the first idle cycle after a result. The bench runs every BCD operand pair in both directions with both extend values, so a single faulty correction case cannot hide.

// File: rtl/bcd_unit_pkg.sv
// Package: shared widths and types for the packed BCD arithmetic unit.
// Assumes one packed byte carries two BCD digits; the intermediate is a
// 10-bit wrapping quantity wide enough for 0x99+0x99+1 plus corrections.
package bcd_unit_pkg;
    localparam int BCD_BYTE_W = 8;
    localparam int BCD_NIB_W  = 4;
    localparam int BCD_INT_W  = 10;

    typedef enum logic {
        BCD_OP_ADD = 1'b0,
        BCD_OP_SUB = 1'b1
    } bcd_op_e;

    typedef struct packed {
        logic x;
        logic c;
        logic z;
        logic n;
        logic v;
    } bcd_flags_t;
endpackage

// File: rtl/bcd_low_step.sv
// Module: low-digit step. Combines the two low nibbles with the extend bit
// (added for add, taken away for subtract) and applies the +/-6 correction
// when the wrapped value, read unsigned, is above 9.
// Assumes: purely combinational; output feeds bcd_high_step.
module bcd_low_step
    import bcd_unit_pkg::*;
#(
    parameter int NIB_W = BCD_NIB_W,
    parameter int INT_W = BCD_INT_W
) (
    input  logic [NIB_W-1:0] dst_lo_i,
    input  logic [NIB_W-1:0] src_lo_i,
    input  logic             ext_i,
    input  bcd_op_e          op_i,
    output logic [INT_W-1:0] partial_o
);
    localparam logic [INT_W-1:0] DIGIT_MAX = INT_W'(9);
    localparam logic [INT_W-1:0] DIGIT_FIX = INT_W'(6);

    logic [INT_W-1:0] raw;

    // Raw low-nibble combination with extend, wrapping at INT_W bits.
    always_comb begin
        if (op_i == BCD_OP_SUB)
            raw = INT_W'(dst_lo_i) - INT_W'(src_lo_i) - INT_W'(ext_i);
        else
            raw = INT_W'(dst_lo_i) + INT_W'(src_lo_i) + INT_W'(ext_i);
    end

    // Decimal correction of the low digit in the operation's direction.
    always_comb begin
        if (raw > DIGIT_MAX)
            partial_o = (op_i == BCD_OP_SUB) ? raw - DIGIT_FIX : raw + DIGIT_FIX;
        else
            partial_o = raw;
    end
endmodule

// File: rtl/bcd_high_step.sv
// Module: high-digit step. Folds the high nibbles into the corrected low
// value and applies the +/-0x60 correction when the total, read unsigned,
// exceeds 0x99.
// Assumes: purely combinational; partial_i comes from bcd_low_step.
module bcd_high_step
    import bcd_unit_pkg::*;
#(
    parameter int NIB_W = BCD_NIB_W,
    parameter int INT_W = BCD_INT_W
) (
    input  logic [INT_W-1:0] partial_i,
    input  logic [NIB_W-1:0] dst_hi_i,
    input  logic [NIB_W-1:0] src_hi_i,
    input  bcd_op_e          op_i,
    output logic [INT_W-1:0] total_o
);
    localparam logic [INT_W-1:0] PAIR_MAX = INT_W'(8'h99);
    localparam logic [INT_W-1:0] PAIR_FIX = INT_W'(8'h60);

    logic [INT_W-1:0] dst_w;
    logic [INT_W-1:0] src_w;
    logic [INT_W-1:0] raw;

    // Place the high nibbles at their digit weight.
    always_comb begin
        dst_w = INT_W'(dst_hi_i) << NIB_W;
        src_w = INT_W'(src_hi_i) << NIB_W;
    end

    // Combine high digits with the intermediate, wrapping at INT_W bits.
    always_comb begin
        if (op_i == BCD_OP_SUB)
            raw = partial_i + dst_w - src_w;
        else
            raw = partial_i + dst_w + src_w;
    end

    // Decimal correction of the high digit in the operation's direction.
    always_comb begin
        if (raw > PAIR_MAX)
            total_o = (op_i == BCD_OP_SUB) ? raw - PAIR_FIX : raw + PAIR_FIX;
        else
            total_o = raw;
    end
endmodule

// File: rtl/bcd_flag_gen.sv
// Module: result byte and condition flags from the corrected total.
// Carry/extend is any bit above the byte; zero can only be cleared;
// overflow uses the sign rule of binary add or subtract.
// Assumes: purely combinational; total_i comes from bcd_high_step.
module bcd_flag_gen
    import bcd_unit_pkg::*;
#(
    parameter int BYTE_W = BCD_BYTE_W,
    parameter int INT_W  = BCD_INT_W
) (
    input  logic [INT_W-1:0]  total_i,
    input  logic [BYTE_W-1:0] src_i,
    input  logic [BYTE_W-1:0] dst_i,
    input  bcd_op_e           op_i,
    input  logic              z_i,
    output logic [BYTE_W-1:0] res_o,
    output bcd_flags_t        flags_o
);
    logic             carry;
    logic [BYTE_W-1:0] ovf_vec;

    // Split the total into result byte and carry-out.
    always_comb begin
        res_o = total_i[BYTE_W-1:0];
        carry = |total_i[INT_W-1:BYTE_W];
    end

    // Sign-rule overflow vector for the selected direction.
    always_comb begin
        if (op_i == BCD_OP_SUB)
            ovf_vec = (src_i ^ dst_i) & (dst_i ^ res_o);
        else
            ovf_vec = ~(src_i ^ dst_i) & (dst_i ^ res_o);
    end

    // Assemble the flag set.
    always_comb begin
        flags_o.x = carry;
        flags_o.c = carry;
        flags_o.z = z_i & (res_o == '0);
        flags_o.n = res_o[BYTE_W-1];
        flags_o.v = ovf_vec[BYTE_W-1];
    end
endmodule

// File: rtl/bcd_arith_unit.sv
// Module: top of the packed BCD add/subtract unit. Computes one byte
// operation combinationally and registers the result and flags on the
// edge where start_i is high; outputs hold between strobes.
// Assumes: synchronous active-low reset; REG_W >= 8; only the low byte of
// the destination register is replaced, higher bits pass through.
module bcd_arith_unit
    import bcd_unit_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  sub_i,
    input  logic [BCD_BYTE_W-1:0] src_i,
    input  logic [REG_W-1:0]      dst_i,
    input  logic                  x_i,
    input  logic                  z_i,
    output logic                  valid_o,
    output logic [REG_W-1:0]      result_o,
    output logic                  x_o,
    output logic                  c_o,
    output logic                  z_o,
    output logic                  n_o,
    output logic                  v_o
);
    localparam int BYTE_W  = BCD_BYTE_W;
    localparam int NIB_W   = BCD_NIB_W;
    localparam int INT_W   = BCD_INT_W;
    localparam int UPPER_W = REG_W - BYTE_W;

    bcd_op_e           op;
    logic [INT_W-1:0]  partial;
    logic [INT_W-1:0]  total;
    logic [BYTE_W-1:0] res_d;
    bcd_flags_t        flags_d;
    logic [BYTE_W-1:0] res_q;
    bcd_flags_t        flags_q;
    logic              valid_q;
    logic              operands_bcd;

    // Decode the operation select.
    always_comb op = sub_i ? BCD_OP_SUB : BCD_OP_ADD;

    bcd_low_step #(.NIB_W(NIB_W), .INT_W(INT_W)) u_low (
        .dst_lo_i  (dst_i[NIB_W-1:0]),
        .src_lo_i  (src_i[NIB_W-1:0]),
        .ext_i     (x_i),
        .op_i      (op),
        .partial_o (partial)
    );

    bcd_high_step #(.NIB_W(NIB_W), .INT_W(INT_W)) u_high (
        .partial_i (partial),
        .dst_hi_i  (dst_i[BYTE_W-1:NIB_W]),
        .src_hi_i  (src_i[BYTE_W-1:NIB_W]),
        .op_i      (op),
        .total_o   (total)
    );

    bcd_flag_gen #(.BYTE_W(BYTE_W), .INT_W(INT_W)) u_flags (
        .total_i (total),
        .src_i   (src_i),
        .dst_i   (dst_i[BYTE_W-1:0]),
        .op_i    (op),
        .z_i     (z_i),
        .res_o   (res_d),
        .flags_o (flags_d)
    );

    // Capture result byte and flags on a strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            valid_q <= start_i;
            if (start_i) begin
                res_q   <= res_d;
                flags_q <= flags_d;
            end
        end
    end

    // Drive the flag outputs from the registered set.
    always_comb begin
        valid_o = valid_q;
        x_o     = flags_q.x;
        c_o     = flags_q.c;
        z_o     = flags_q.z;
        n_o     = flags_q.n;
        v_o     = flags_q.v;
    end

    generate
        if (UPPER_W > 0) begin : g_keep_upper
            logic [UPPER_W-1:0] upper_q;

            // Capture the untouched upper destination bits on a strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    upper_q <= '0;
                else if (start_i)
                    upper_q <= dst_i[REG_W-1:BYTE_W];
            end

            assign result_o = {upper_q, res_q};

            assert_upper_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
                start_i |=> result_o[REG_W-1:BYTE_W] == $past(dst_i[REG_W-1:BYTE_W]));
        end else begin : g_byte_only
            assign result_o = res_q;
        end
    endgenerate

    // Operand range check used by the decimal-form assertions.
    always_comb begin
        operands_bcd = (src_i[NIB_W-1:0] <= 4'd9) && (src_i[BYTE_W-1:NIB_W] <= 4'd9) &&
                       (dst_i[NIB_W-1:0] <= 4'd9) && (dst_i[BYTE_W-1:NIB_W] <= 4'd9);
    end

    assert_valid_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!valid_o && $stable(result_o) && $stable(z_o) && $stable(x_o)));

    assert_add_digits_decimal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !sub_i && operands_bcd) |=>
            (result_o[NIB_W-1:0] <= 4'd9 && result_o[BYTE_W-1:NIB_W] <= 4'd9));

    assert_sub_digits_decimal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sub_i && operands_bcd) |=>
            (result_o[NIB_W-1:0] <= 4'd9 && result_o[BYTE_W-1:NIB_W] <= 4'd9));

    assert_zero_only_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !z_i) |=> !z_o);
endmodule

// File: tb/bcd_arith_unit_tb.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them whenever the unit presents a result.
module bcd_arith_unit_tb;
    localparam int REG_W = 32;

    typedef struct {
        logic [31:0] res;
        logic x, c, z, n, v;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sub_i = 1'b0;
    logic [7:0]  src_i = '0;
    logic [31:0] dst_i = '0;
    logic        x_i = 1'b0;
    logic        z_i = 1'b0;
    logic        valid_o;
    logic [31:0] result_o;
    logic        x_o, c_o, z_o, n_o, v_o;

    int   checks = 0;
    int   failures = 0;
    int   cycles = 0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #2 clk = ~clk;

    bcd_arith_unit #(.REG_W(REG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
        .src_i(src_i), .dst_i(dst_i), .x_i(x_i), .z_i(z_i),
        .valid_o(valid_o), .result_o(result_o), .x_o(x_o), .c_o(c_o),
        .z_o(z_o), .n_o(n_o), .v_o(v_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Decimal reference for valid BCD operands (R3, R4, R5).
    function automatic exp_t model_dec(input logic sub, input logic [7:0] s,
                                       input logic [31:0] d, input logic x, input logic z);
        exp_t e;
        int ds = s[7:4] * 10 + s[3:0];
        int dd = d[7:4] * 10 + d[3:0];
        int v;
        logic cy;
        logic [7:0] r;
        v  = sub ? dd - ds - int'(x) : dd + ds + int'(x);
        cy = sub ? (v < 0) : (v >= 100);
        if (cy) v = sub ? v + 100 : v - 100;
        r = {4'(v / 10), 4'(v % 10)};
        e.res = {d[31:8], r};
        e.x = cy; e.c = cy;
        e.z = z & (r == 8'h00);
        e.n = r[7];
        e.v = sub ? (((s ^ d[7:0]) & (d[7:0] ^ r)) >> 7) != 0
                  : ((~(s ^ d[7:0]) & (d[7:0] ^ r)) >> 7) != 0;
        return e;
    endfunction

    // 10-bit wrapping nibble procedure for arbitrary operands (R10).
    function automatic exp_t model_raw(input logic sub, input logic [7:0] s,
                                       input logic [31:0] d, input logic x, input logic z);
        exp_t e;
        logic [9:0] t;
        logic [7:0] r;
        t = sub ? 10'(d[3:0]) - 10'(s[3:0]) - 10'(x) : 10'(d[3:0]) + 10'(s[3:0]) + 10'(x);
        if (t > 10'd9) t = sub ? t - 10'd6 : t + 10'd6;
        t = sub ? t + {2'b0, d[7:4], 4'b0} - {2'b0, s[7:4], 4'b0}
                : t + {2'b0, d[7:4], 4'b0} + {2'b0, s[7:4], 4'b0};
        if (t > 10'h099) t = sub ? t - 10'h060 : t + 10'h060;
        r = t[7:0];
        e.res = {d[31:8], r};
        e.x = |t[9:8]; e.c = |t[9:8];
        e.z = z & (r == 8'h00);
        e.n = r[7];
        e.v = sub ? (((s ^ d[7:0]) & (d[7:0] ^ r)) >> 7) != 0
                  : ((~(s ^ d[7:0]) & (d[7:0] ^ r)) >> 7) != 0;
        return e;
    endfunction

    // Driver: present one operation for one cycle and push its expectation.
    task automatic issue(input logic sub, input logic [7:0] s, input logic [31:0] d,
                         input logic x, input logic z, input bit bcd);
        exp_t e;
        e = bcd ? model_dec(sub, s, d, x, z) : model_raw(sub, s, d, x, z);
        sub_i = sub; src_i = s; dst_i = d; x_i = x; z_i = z;
        start_i = 1'b1;
        sb_q.push_back(e);
        last_exp = e;
        @(negedge clk);
    endtask

    // Monitor: pop and compare each presented result.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (sb_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R2 actual=unexpected valid expected=no valid");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check("R3/R4 result byte", {24'h0, result_o[7:0]}, {24'h0, e.res[7:0]});
                check("R9 upper bits", {8'h0, result_o[31:8]}, {8'h0, e.res[31:8]});
                check("R5 x/c", {30'h0, x_o, c_o}, {30'h0, e.x, e.c});
                check("R6 zero", {31'h0, z_o}, {31'h0, e.z});
                check("R7 negative", {31'h0, n_o}, {31'h0, e.n});
                check("R8 overflow", {31'h0, v_o}, {31'h0, e.v});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] odd_vals [6];
        odd_vals = '{8'h0A, 8'h0F, 8'hA0, 8'hFF, 8'h9A, 8'h5C};

        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 valid", {31'h0, valid_o}, 32'h0);
        check("R1 result", result_o, 32'h0);
        check("R1 flags", {27'h0, x_o, c_o, z_o, n_o, v_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R4, R5, R6, R7, R8, R9: every BCD pair, both directions, both extend values.
        for (int op = 0; op < 2; op++)
            for (int xv = 0; xv < 2; xv++)
                for (int a = 0; a < 100; a++)
                    for (int b = 0; b < 100; b++) begin
                        logic [7:0] sb = {4'(a / 10), 4'(a % 10)};
                        logic [7:0] db = {4'(b / 10), 4'(b % 10)};
                        issue(op[0], sb, {8'(a), 8'(b), 8'(a ^ b), db}, xv[0], ((a + b) % 3) != 0, 1'b1);
                    end

        // R10: non-BCD nibbles follow the wrapping procedure.
        for (int op = 0; op < 2; op++)
            for (int xv = 0; xv < 2; xv++)
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        issue(op[0], odd_vals[i], {24'hC0FFEE, odd_vals[j]}, xv[0], 1'b1, 1'b0);

        // R6: zero chain across a multi-byte subtraction 0x0000 - 0x0000 then nonzero.
        issue(1'b1, 8'h00, 32'h0, 1'b0, 1'b1, 1'b1);
        issue(1'b1, 8'h01, 32'h0, 1'b0, 1'b0, 1'b1);

        // R2: idle cycles with changing inputs must not disturb outputs.
        start_i = 1'b0;
        @(negedge clk);
        src_i = 8'h55; dst_i = 32'h12345678; sub_i = 1'b0; x_i = 1'b1; z_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 hold result", result_o, last_exp.res);
        check("R2 hold flags", {27'h0, x_o, c_o, z_o, n_o, v_o},
              {27'h0, last_exp.x, last_exp.c, last_exp.z, last_exp.n, last_exp.v});
        check("R2 valid low", {31'h0, valid_o}, 32'h0);
        check("R2 scoreboard drained", sb_q.size(), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule